// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block is the host-side unit through which software reaches a bank of 32-bit configuration registers in a bus bridge. It sits on a plain I/O bus that carries a port address, an access size of 1, 2 or 4 bytes, write data, and one-cycle read and write strobes. Software first writes a 32-bit pointer into an address latch at one port. It then reads or writes the selected register through a four-byte data window. The window's byte offset is the low two bits of the port address.

The block does the byte-lane work for each window access. On a write it shifts the data into place, masks the lanes and merges the result with the register's old contents. On a read it shifts the register down to the offset and trims it to the access size. An offset and size pair that would run past the end of the window writes nothing. Undecoded ports return all ones and raise a one-cycle error pulse. Strobes are plain control pins with no back-pressure: every strobe is taken in the cycle it is seen. The block cannot stall, so there is no ready signal, and read data is always valid in the cycle after the read strobe.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write of any size to port 0xCF8 stores the whole 32-bit `io_wdata` into the address latch.
- R2: Ports 0xCFC to 0xCFF form the data window, and the window offset is `io_addr[1:0]`. The target register index is latch bits 7:2. Latch bits 1:0 and bits 30:8 do not affect which register is selected.
- R3: A window write changes nothing when latch bit 31 is 0.
- R4: When latch bit 31 is 1, a window write at offset N places `io_wdata` shifted left by 8*N bits into the enabled byte lanes. All other lanes of the register keep their old value.
- R5: The size codes are 1, 2 and 4 bytes. Offset 0 accepts sizes 1, 2 and 4. Offsets 1 and 2 accept sizes 1 and 2. Offset 3 accepts size 1 only. Any other pair, including size code 3, leaves the register unchanged.
- R6: A window read at offset N returns the selected register shifted right by 8*N bits. The result is masked to 8 bits for size 1, to 16 bits for size 2, and to 32 bits for any other size code. Reads do not depend on latch bit 31.
- R7: `io_rdata` and `io_rvalid` are registered. `io_rvalid` is high exactly in the cycle after a read strobe and is low otherwise.
- R8: A synchronous active-high reset clears the address latch, every configuration register, `io_rdata`, `io_rvalid` and `io_err`.
- R9: A read of any port outside 0xCFC to 0xCFF, including 0xCF8, returns 0xFFFFFFFF and pulses `io_err` for one cycle.
- R10: A write to a port that is neither 0xCF8 nor in the window pulses `io_err` for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes (1, 2 or 4) |
| io_wdata | input | 32 | Write data, right-aligned |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 32 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | High in the cycle after a read strobe |
| io_err | output | 1 | One-cycle pulse after an undecoded access |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that address, size and data are steady only for the strobed cycle, because the block samples them at that one edge. The bench drives each strobe for exactly one cycle, starting on the falling edge, and never raises both strobes together. It draws sizes from 1 to 4, so the illegal code 3 is also exercised. It picks undecoded ports that avoid the window, and for writes it also avoids the address latch.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_ADDR = 2'd1,
    PORT_DATA = 2'd2
  } port_kind_e;

  localparam int unsigned SIZE_W = 3;
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
#(
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned OFF_W     = 2,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_BASE = 16'h0CFC
) (
  input  logic [PORT_W-1:0] port,
  output port_kind_e        kind,
  output logic [OFF_W-1:0]  offset
);
  logic hit_addr, hit_data;

  assign hit_addr = (port == ADDR_PORT[PORT_W-1:0]);
  assign hit_data = (port[PORT_W-1:OFF_W] == DATA_BASE[PORT_W-1:OFF_W]);
  assign offset   = port[OFF_W-1:0];

  always_comb begin
    if (hit_data)      kind = PORT_DATA;
    else if (hit_addr) kind = PORT_ADDR;
    else               kind = PORT_NONE;
  end
endmodule

// File: rtl/cfgb_lane_merge.sv
module cfgb_lane_merge
  import cfgb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] old_word,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged
);
  logic [LANES-1:0]   base;
  logic [2*LANES-1:0] wide;
  logic [DATA_W-1:0]  shifted;

  always_comb begin
    case (size)
      3'd1:    base = LANES'(4'b0001);
      3'd2:    base = LANES'(4'b0011);
      3'd4:    base = LANES'(4'b1111);
      default: base = '0;
    endcase
  end

  // A lane pattern that spills past the window top is illegal as a whole.
  assign wide    = {{LANES{1'b0}}, base} << offset;
  assign lane_en = (wide[2*LANES-1:LANES] == '0) ? wide[LANES-1:0] : '0;
  assign shifted = wdata << {offset, 3'b000};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[8*l +: 8] = lane_en[l] ? shifted[8*l +: 8] : old_word[8*l +: 8];
  end

  always_comb begin
    if (offset == OFF_W'(LANES - 1))
      a_r5_top_offset_single: assert (lane_en == '0 || lane_en == LANES'(1 << (LANES - 1)));
  end
endmodule

// File: rtl/cfgb_read_align.sv
module cfgb_read_align
  import cfgb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  offset,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] shifted, keep;

  assign shifted = word >> {offset, 3'b000};

  always_comb begin
    case (size)
      3'd1:    keep = DATA_W'(32'h0000_00FF);
      3'd2:    keep = DATA_W'(32'h0000_FFFF);
      default: keep = '1;
    endcase
  end

  assign data = shifted & keep;
endmodule

// File: rtl/cfgb_regbank.sv
module cfgb_regbank #(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                               q <= '0;
      else if (wr_en && idx == IDX_W'(g))    q <= wr_data;
    end
    assign words[g] = q;
  end

  assign rd_data = words[idx];
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 64,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_BASE = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] io_addr,
  input  logic [2:0]        io_size,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              io_err
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  port_kind_e        kind;
  logic [OFF_W-1:0]  offset;
  logic [DATA_W-1:0] cfg_addr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel_word, merged, aligned;
  logic [LANES-1:0]  lane_en;
  logic              bank_we;
  logic              unused_addr_bits;

  assign idx              = cfg_addr[OFF_W +: IDX_W];
  assign unused_addr_bits = ^{cfg_addr[DATA_W-2:OFF_W+IDX_W], cfg_addr[OFF_W-1:0]};

  cfgb_decode #(
    .PORT_W(PORT_W), .OFF_W(OFF_W), .ADDR_PORT(ADDR_PORT), .DATA_BASE(DATA_BASE)
  ) u_decode (
    .port(io_addr), .kind(kind), .offset(offset)
  );

  cfgb_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .offset(offset), .size(io_size), .wdata(io_wdata), .old_word(sel_word),
    .lane_en(lane_en), .merged(merged)
  );

  cfgb_read_align #(.DATA_W(DATA_W)) u_align (
    .word(sel_word), .offset(offset), .size(io_size), .data(aligned)
  );

  assign bank_we = io_wr && (kind == PORT_DATA) && cfg_addr[DATA_W-1] && (lane_en != '0);

  cfgb_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(bank_we), .wr_data(merged), .rd_data(sel_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr  <= '0;
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
      io_err    <= 1'b0;
    end else begin
      if (io_wr && kind == PORT_ADDR) cfg_addr <= io_wdata;
      if (io_rd) io_rdata <= (kind == PORT_DATA) ? aligned : '1;
      io_rvalid <= io_rd;
      io_err    <= (io_rd && kind != PORT_DATA) || (io_wr && kind == PORT_NONE);
    end
  end

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));
  a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> io_rvalid);
  a_r7_rvalid_idle: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> !io_rvalid);
  a_r1_latch_full_word: assert property (@(posedge clk) disable iff (rst)
    (io_wr && kind == PORT_ADDR) |=> (cfg_addr == $past(io_wdata)));
  a_r3_disabled_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (io_wr && kind == PORT_DATA && !cfg_addr[DATA_W-1]) |=> $stable(sel_word));
  a_r5_illegal_pair_no_change: assert property (@(posedge clk) disable iff (rst)
    (io_wr && kind == PORT_DATA && lane_en == '0) |=> $stable(sel_word));
  a_r9_undecoded_read_ones: assert property (@(posedge clk) disable iff (rst)
    (io_rd && kind != PORT_DATA) |=> (io_err && io_rdata == '1));
endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  logic        io_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_regs [64];
  logic [31:0] m_caddr;

  always #10 clk = ~clk;

  cfg_port_bridge i_cfg_port_bridge (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .io_err(io_err)
  );

  function automatic logic [3:0] exp_lanes(input logic [1:0] off, input logic [2:0] sz);
    case (off)
      2'd0: exp_lanes = (sz == 1) ? 4'h1 : (sz == 2) ? 4'h3 : (sz == 4) ? 4'hF : 4'h0;
      2'd1: exp_lanes = (sz == 1) ? 4'h2 : (sz == 2) ? 4'h6 : 4'h0;
      2'd2: exp_lanes = (sz == 1) ? 4'h4 : (sz == 2) ? 4'hC : 4'h0;
      default: exp_lanes = (sz == 1) ? 4'h8 : 4'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [1:0] off,
                                           input logic [2:0] sz);
    logic [31:0] s;
    s = w >> (8 * off);
    if (sz == 1)      exp_read = s & 32'hFF;
    else if (sz == 2) exp_read = s & 32'hFFFF;
    else              exp_read = s;
  endfunction

  function automatic bit in_window(input logic [15:0] a);
    in_window = (a[15:2] == 14'h033F);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [3:0]  ln;
    logic [31:0] sh;
    int          ix;
    if (a == 16'h0CF8) m_caddr = d;
    else if (in_window(a) && m_caddr[31]) begin
      ln = exp_lanes(a[1:0], sz);
      sh = d << (8 * a[1:0]);
      ix = int'(m_caddr[7:2]);
      for (int l = 0; l < 4; l++)
        if (ln[l]) m_regs[ix][8*l +: 8] = sh[8*l +: 8];
    end
  endtask

  task automatic do_write(input string req, input logic [15:0] a, input logic [2:0] sz,
                          input logic [31:0] d);
    bit bad;
    bad = (a != 16'h0CF8) && !in_window(a);
    io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, sz, d);
    check(req, {30'd0, io_rvalid, io_err}, {30'd0, 1'b0, bad});
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input logic [2:0] sz);
    logic [31:0] exp;
    bit          bad;
    bad = !in_window(a);
    exp = bad ? 32'hFFFF_FFFF : exp_read(m_regs[int'(m_caddr[7:2])], a[1:0], sz);
    io_addr = a; io_size = sz; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(req, io_rdata, exp);
    check(req, {30'd0, io_rvalid, io_err}, {30'd0, 1'b1, bad});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] pa;
    logic [2:0]  sz;
    logic [31:0] v;
    void'($urandom(32'h0C0F_F1CE));
    for (int i = 0; i < 64; i++) m_regs[i] = '0;
    m_caddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: outputs cleared
    check("R8", io_rdata, 32'h0);
    check("R8", {30'd0, io_rvalid, io_err}, 32'h0);
    do_read("R8", 16'h0CFC, 3'd4);
    // R7: rvalid is a single pulse
    @(negedge clk);
    check("R7", {31'd0, io_rvalid}, 32'h0);
    // R3: latch bit 31 clear drops window writes
    do_write("R1", 16'h0CF8, 3'd1, 32'h0000_0014);
    do_write("R3", 16'h0CFC, 3'd4, 32'hAABB_CCDD);
    do_read("R3", 16'h0CFC, 3'd4);
    // R1: size-1 latch write still stores bit 31 and index
    do_write("R1", 16'h0CF8, 3'd1, 32'h8000_0014);
    do_write("R4", 16'h0CFC, 3'd4, 32'h1122_3344);
    do_read("R1", 16'h0CFC, 3'd4);
    // R2: low bits and bits 30:8 do not select
    do_write("R2", 16'h0CF8, 3'd4, 32'hC5A3_0117);
    do_read("R2", 16'h0CFC, 3'd4);
    // R5: illegal pairs leave the word intact
    do_write("R5", 16'h0CFF, 3'd2, 32'h0000_FFFF);
    do_write("R5", 16'h0CFD, 3'd4, 32'hFFFF_FFFF);
    do_write("R5", 16'h0CFC, 3'd3, 32'hFFFF_FFFF);
    do_write("R5", 16'h0CFE, 3'd4, 32'hFFFF_FFFF);
    do_read("R5", 16'h0CFC, 3'd4);
    // R4: merge into middle lanes
    do_write("R4", 16'h0CFD, 3'd2, 32'h0000_BEEF);
    do_read("R4", 16'h0CFC, 3'd4);
    do_write("R4", 16'h0CFF, 3'd1, 32'h0000_00A5);
    // R6: aligned reads
    do_read("R6", 16'h0CFD, 3'd2);
    do_read("R6", 16'h0CFF, 3'd1);
    do_read("R6", 16'h0CFE, 3'd4);
    do_read("R6", 16'h0CFD, 3'd3);
    // R6: reads ignore bit 31
    do_write("R6", 16'h0CF8, 3'd4, 32'h0000_0014);
    do_read("R6", 16'h0CFC, 3'd4);
    do_write("R6", 16'h0CF8, 3'd4, 32'h8000_0014);
    // R9: undecoded reads
    do_read("R9", 16'h0CF8, 3'd4);
    do_read("R9", 16'h0080, 3'd1);
    do_read("R9", 16'h0D00, 3'd2);
    // R10: undecoded writes change nothing
    do_write("R10", 16'h0CFB, 3'd4, 32'h8000_0000);
    do_write("R10", 16'h0CF9, 3'd4, 32'h0000_0000);
    do_read("R10", 16'h0CFC, 3'd4);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom % 10;
      sz = 3'(1 + ($urandom % 4));
      v  = $urandom;
      pa = 16'h0CFC + 16'($urandom % 4);
      if (op == 0) begin
        v[31] = ($urandom % 8) != 0;
        do_write("R2", 16'h0CF8, sz, v);
      end else if (op < 5) begin
        do_write("R4", pa, sz, v);
      end else if (op < 9) begin
        do_read("R6", pa, sz);
      end else begin
        pa = 16'($urandom);
        if (pa == 16'h0CF8 || in_window(pa)) pa = 16'h0100;
        if ($urandom % 2) do_write("R10", pa, sz, v);
        else              do_read("R9", pa, sz);
      end
    end
    finish_run();
  end
endmodule